// File: doc/BRIEF.md
# I2C Status Flag Controller

This block gathers the event pulses that an I2C/SMBus protocol engine produces and turns them into sticky status flags for a register interface. The events are: byte transferred, START or STOP requested, misplaced START/STOP, arbitration loss, overrun or underrun, PEC mismatch, timeout, and a falling edge on the external alert pin. It also holds a transfer byte counter. Software loads the counter with a count, and each byte-done pulse decrements it. The counter's terminal byte decides which completion flag is raised.

Each flag has its own clear rule. The final-complete flag clears on a START or STOP request. The reload-complete flag clears when a nonzero count is written. Every error and alert flag clears through its own clear strobe. Dropping the peripheral enable wipes all flags at once. A PEC mismatch also produces a one-cycle NACK request back to the engine. When the block is built without SMBus support, the SMBus-only flags and the NACK request are tied to zero.

Top module: `i2c_flag_ctrl`

## Requirements
- R1: A `cnt_wr_i` pulse loads `cnt_wdata_i` into the counter on that clock edge, taking priority over a byte-done pulse in the same cycle; the load works whether or not the peripheral is enabled.
- R2: With `en_i` high and no load, each `byte_done_i` decrements a nonzero counter by one. At zero the counter holds. `cnt_zero_o` is high exactly when the counter reads zero. The terminal byte is a byte-done that takes the counter from 1 to 0.
- R3: Flag bit 0 (transfer complete) sets on the edge after a terminal byte when reload and auto-end are both off. It clears on a `start_req_i` or `stop_req_i`. A set in the same cycle as a clear wins.
- R4: Flag bit 1 (reload complete) sets after a terminal byte when reload is on and either master mode or slave byte control is on. It clears when a nonzero count is written.
- R5: Flag bit 2 (bus error) sets on `bus_err_i` and flag bit 3 (arbitration lost) sets on `arb_lost_i`. They clear only through `clr_i[0]` and `clr_i[1]` respectively. A set wins over a clear in the same cycle.
- R6: Flag bit 4 (overrun/underrun) sets on `ovr_udr_i` only while master mode is off and clock stretching is disabled. It clears through `clr_i[2]`.
- R7: Flag bit 5 (PEC error) sets on `pec_err_i` and clears through `clr_i[3]`. `nack_req_o` is high for exactly the cycle after each enabled `pec_err_i`.
- R8: Flag bit 6 (timeout) sets on `timeout_i` and clears through `clr_i[4]`.
- R9: Flag bit 7 (alert) sets on the third rising edge after the `alert_ni` pin falls, and only when host-address mode and alert enable are both on. It clears through `clr_i[5]`.
- R10: With `SMBUS_EN` = 0, flag bits 7:5 and `nack_req_o` are constant zero.
- R11: While `en_i` is low, `flags_o` reads zero in that same cycle, all flag registers clear on the next edge, and no event sets a flag.
- R12: Reset drives all flags, the counter and `nack_req_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Peripheral enable |
| master_i | input | 1 | Master mode |
| slv_byte_ctl_i | input | 1 | Slave byte control enable |
| reload_i | input | 1 | Reload mode |
| auto_end_i | input | 1 | Automatic end mode |
| stretch_dis_i | input | 1 | Clock stretching disabled |
| host_addr_i | input | 1 | SMBus host-address mode |
| alert_en_i | input | 1 | Alert detection enable |
| cnt_wr_i | input | 1 | Byte count write strobe |
| cnt_wdata_i | input | CNT_W | Byte count write value |
| byte_done_i | input | 1 | One byte transferred |
| start_req_i | input | 1 | START requested |
| stop_req_i | input | 1 | STOP requested |
| bus_err_i | input | 1 | Misplaced START/STOP seen |
| arb_lost_i | input | 1 | Arbitration lost |
| ovr_udr_i | input | 1 | Overrun or underrun |
| pec_err_i | input | 1 | Received PEC mismatch |
| timeout_i | input | 1 | Timeout detected |
| alert_ni | input | 1 | Asynchronous alert pin, active low |
| clr_i | input | 6 | Clear strobes: 0 bus err, 1 arb, 2 ovr, 3 pec, 4 timeout, 5 alert |
| flags_o | output | 8 | Flags: 0 tc, 1 tcr, 2 bus err, 3 arb, 4 ovr, 5 pec, 6 timeout, 7 alert |
| cnt_o | output | CNT_W | Remaining byte count |
| cnt_zero_o | output | 1 | Counter is zero |
| nack_req_o | output | 1 | Automatic NACK request |

## Verification
A counter that is one step off shows up at `cnt_o` on the very next cycle. Its deeper effect comes later, when the terminal byte fires a byte early or late and the wrong completion flag sets or one is missed. A flag register stuck in a wrong state stays wrong until a clear rule or the enable drop removes it, so a per-cycle comparison catches it on the first sampled cycle. An alert synchronizer of the wrong depth shifts the alert flag by a cycle, which shows as a one-cycle mismatch at bit 7 on each pin fall.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;
  localparam int NUM_FLAGS = 8;
  localparam int NUM_CLR   = 6;

  localparam int F_TC    = 0;
  localparam int F_TCR   = 1;
  localparam int F_BERR  = 2;
  localparam int F_ARB   = 3;
  localparam int F_OVR   = 4;
  localparam int F_PEC   = 5;
  localparam int F_TTO   = 6;
  localparam int F_ALERT = 7;

  localparam int C_BERR  = 0;
  localparam int C_ARB   = 1;
  localparam int C_OVR   = 2;
  localparam int C_PEC   = 3;
  localparam int C_TTO   = 4;
  localparam int C_ALERT = 5;

  // flags that exist only with SMBus support
  localparam logic [NUM_FLAGS-1:0] SMB_ONLY_MASK = 8'b1110_0000;

  typedef struct packed {
    logic reload;
    logic auto_end;
    logic master;
    logic slv_byte_ctl;
    logic stretch_dis;
    logic host_addr;
    logic alert_en;
  } flag_cfg_t;
endpackage

// File: rtl/i2c_alert_sync.sv
module i2c_alert_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];

  a_r9_single_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/i2c_byte_cnt.sv
module i2c_byte_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             byte_done_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o,
  output logic             term_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             dec;

  assign dec    = en_i & byte_done_i & ~wr_i & (cnt_q != '0);
  assign term_o = dec & (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (wr_i) cnt_q <= wdata_i;
    else if (dec)  cnt_q <= cnt_q - ONE;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  a_r1_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_o == $past(wdata_i));
  a_r2_hold_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !wr_i) |=> zero_o);
  a_r2_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !zero_o && en_i && byte_done_i) |=> cnt_o == $past(cnt_o) - ONE);
endmodule

// File: rtl/i2c_sticky_flag.sv
module i2c_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (!en_i)  q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;   // set beats clear
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/i2c_flag_ctrl.sv
module i2c_flag_ctrl
  import i2c_flag_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter bit SMBUS_EN    = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 master_i,
  input  logic                 slv_byte_ctl_i,
  input  logic                 reload_i,
  input  logic                 auto_end_i,
  input  logic                 stretch_dis_i,
  input  logic                 host_addr_i,
  input  logic                 alert_en_i,
  input  logic                 cnt_wr_i,
  input  logic [CNT_W-1:0]     cnt_wdata_i,
  input  logic                 byte_done_i,
  input  logic                 start_req_i,
  input  logic                 stop_req_i,
  input  logic                 bus_err_i,
  input  logic                 arb_lost_i,
  input  logic                 ovr_udr_i,
  input  logic                 pec_err_i,
  input  logic                 timeout_i,
  input  logic                 alert_ni,
  input  logic [NUM_CLR-1:0]   clr_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 cnt_zero_o,
  output logic                 nack_req_o
);
  flag_cfg_t            cfg;
  logic                 term;
  logic                 alert_fall;
  logic [NUM_FLAGS-1:0] set_v, clr_v, flag_q;

  assign cfg = '{reload: reload_i, auto_end: auto_end_i, master: master_i,
                 slv_byte_ctl: slv_byte_ctl_i, stretch_dis: stretch_dis_i,
                 host_addr: host_addr_i, alert_en: alert_en_i};

  i2c_byte_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .wr_i        (cnt_wr_i),
    .wdata_i     (cnt_wdata_i),
    .byte_done_i (byte_done_i),
    .cnt_o       (cnt_o),
    .zero_o      (cnt_zero_o),
    .term_o      (term)
  );

  i2c_alert_sync #(.STAGES(SYNC_STAGES)) u_alert (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (alert_ni),
    .fall_o (alert_fall)
  );

  always_comb begin
    set_v          = '0;
    clr_v          = '0;
    set_v[F_TC]    = term & ~cfg.reload & ~cfg.auto_end;
    clr_v[F_TC]    = start_req_i | stop_req_i;
    set_v[F_TCR]   = term & cfg.reload & (cfg.master | cfg.slv_byte_ctl);
    clr_v[F_TCR]   = cnt_wr_i & (cnt_wdata_i != '0);
    set_v[F_BERR]  = bus_err_i;
    clr_v[F_BERR]  = clr_i[C_BERR];
    set_v[F_ARB]   = arb_lost_i;
    clr_v[F_ARB]   = clr_i[C_ARB];
    set_v[F_OVR]   = ovr_udr_i & ~cfg.master & cfg.stretch_dis;
    clr_v[F_OVR]   = clr_i[C_OVR];
    set_v[F_PEC]   = pec_err_i;
    clr_v[F_PEC]   = clr_i[C_PEC];
    set_v[F_TTO]   = timeout_i;
    clr_v[F_TTO]   = clr_i[C_TTO];
    set_v[F_ALERT] = alert_fall & cfg.host_addr & cfg.alert_en;
    clr_v[F_ALERT] = clr_i[C_ALERT];
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    if (SMB_ONLY_MASK[i] && !SMBUS_EN) begin : g_tied
      assign flag_q[i] = 1'b0;
    end else begin : g_reg
      i2c_sticky_flag u_flag (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .set_i  (set_v[i]),
        .clr_i  (clr_v[i]),
        .q_o    (flag_q[i])
      );
    end
  end

  // disable hides flags in the same cycle
  assign flags_o = flag_q & {NUM_FLAGS{en_i}};

  if (SMBUS_EN) begin : g_nack
    logic nack_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) nack_q <= 1'b0;
      else         nack_q <= en_i & pec_err_i;
    end
    assign nack_req_o = nack_q;

    a_r7_nack_follows_pec: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && pec_err_i) |=> (nack_req_o && flag_q[F_PEC]));
  end else begin : g_no_nack
    assign nack_req_o = 1'b0;
  end

  a_r11_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (flag_q == '0));
  a_r3_tc_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term && !reload_i && !auto_end_i) |=> flag_q[F_TC]);
  a_r4_tcr_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[F_TCR] && !$past(flag_q[F_TCR])) |->
      $past(reload_i && (master_i || slv_byte_ctl_i)));
  a_r6_ovr_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[F_OVR] && !$past(flag_q[F_OVR])) |->
      $past(!master_i && stretch_dis_i));
  a_r5_berr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[F_BERR] && en_i && !clr_i[C_BERR]) |=> flag_q[F_BERR]);
endmodule

// File: tb/i2c_flag_ctrl_tb.sv
module i2c_flag_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en, master, sbc, reload, auto_end, sdis, haddr, aen;
  logic cwr, bdone, start, stop, berr, arb, ovr, pec, tto, pin;
  logic [CW-1:0] wdata;
  logic [5:0] clr;
  logic [7:0] flags, flags_n;
  logic [CW-1:0] cnt, cnt_n;
  logic zero, zero_n, nack, nack_n;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_flag_ctrl #(.CNT_W(CW), .SMBUS_EN(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .master_i(master), .slv_byte_ctl_i(sbc),
    .reload_i(reload), .auto_end_i(auto_end), .stretch_dis_i(sdis), .host_addr_i(haddr),
    .alert_en_i(aen), .cnt_wr_i(cwr), .cnt_wdata_i(wdata), .byte_done_i(bdone),
    .start_req_i(start), .stop_req_i(stop), .bus_err_i(berr), .arb_lost_i(arb),
    .ovr_udr_i(ovr), .pec_err_i(pec), .timeout_i(tto), .alert_ni(pin), .clr_i(clr),
    .flags_o(flags), .cnt_o(cnt), .cnt_zero_o(zero), .nack_req_o(nack));

  i2c_flag_ctrl #(.CNT_W(CW), .SMBUS_EN(1'b0)) u_dut_nosmb (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .master_i(master), .slv_byte_ctl_i(sbc),
    .reload_i(reload), .auto_end_i(auto_end), .stretch_dis_i(sdis), .host_addr_i(haddr),
    .alert_en_i(aen), .cnt_wr_i(cwr), .cnt_wdata_i(wdata), .byte_done_i(bdone),
    .start_req_i(start), .stop_req_i(stop), .bus_err_i(berr), .arb_lost_i(arb),
    .ovr_udr_i(ovr), .pec_err_i(pec), .timeout_i(tto), .alert_ni(pin), .clr_i(clr),
    .flags_o(flags_n), .cnt_o(cnt_n), .cnt_zero_o(zero_n), .nack_req_o(nack_n));

  // behavioural reference model
  int m_cnt = 0;
  bit [7:0] m_f = '0;
  bit m_nack = 1'b0;
  bit pin_hist[$] = '{1'b1, 1'b1, 1'b1};
  bit m_done, m_fall;
  bit [7:0] nf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_f = '0; m_nack = 1'b0;
      pin_hist = '{1'b1, 1'b1, 1'b1};
    end else begin
      m_done = en && bdone && !cwr && (m_cnt == 1);
      m_fall = (pin_hist[1] == 1'b0) && (pin_hist[2] == 1'b1);
      nf = m_f;
      if (!en) nf = '0;
      else begin
        if (start || stop) nf[0] = 1'b0;
        if (m_done && !reload && !auto_end) nf[0] = 1'b1;
        if (cwr && wdata != 0) nf[1] = 1'b0;
        if (m_done && reload && (master || sbc)) nf[1] = 1'b1;
        if (clr[0]) nf[2] = 1'b0;
        if (berr) nf[2] = 1'b1;
        if (clr[1]) nf[3] = 1'b0;
        if (arb) nf[3] = 1'b1;
        if (clr[2]) nf[4] = 1'b0;
        if (ovr && !master && sdis) nf[4] = 1'b1;
        if (clr[3]) nf[5] = 1'b0;
        if (pec) nf[5] = 1'b1;
        if (clr[4]) nf[6] = 1'b0;
        if (tto) nf[6] = 1'b1;
        if (clr[5]) nf[7] = 1'b0;
        if (m_fall && haddr && aen) nf[7] = 1'b1;
      end
      m_f = nf;
      if (cwr) m_cnt = int'(wdata);
      else if (en && bdone && m_cnt > 0) m_cnt = m_cnt - 1;
      m_nack = en && pec;
      pin_hist.push_front(pin);
      void'(pin_hist.pop_back());
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string flag_tag(input int b, input bit enabled);
    if (!enabled) return "R11";
    case (b)
      0: return "R3";
      1: return "R4";
      2, 3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic compare();
    bit [7:0] exp_f;
    exp_f = en ? m_f : 8'h00;
    for (int b = 0; b < 8; b++)
      chk(flags[b] == exp_f[b], flag_tag(b, en), int'(flags[b]), int'(exp_f[b]));
    chk(cnt == CW'(m_cnt), "R1 count", int'(cnt), m_cnt);
    chk(zero == (m_cnt == 0), "R2 zero", int'(zero), int'(m_cnt == 0));
    chk(nack == m_nack, "R7 nack", int'(nack), int'(m_nack));
    chk(flags_n[7:5] == 3'b000 && nack_n == 1'b0, "R10 smbus off",
        int'({flags_n[7:5], nack_n}), 0);
    chk(flags_n[4:0] == exp_f[4:0], "R10 base flags", int'(flags_n[4:0]), int'(exp_f[4:0]));
  endtask

  task automatic drive(input int ph);
    en       = (ph % 4 == 3) ? ($urandom_range(0, 9) != 0) : ($urandom_range(0, 99) > 2);
    cwr      = ($urandom_range(0, 99) < 8);
    wdata    = CW'($urandom_range(0, 4));
    bdone    = ($urandom_range(0, 1) == 1);
    start    = ($urandom_range(0, 99) < 3);
    stop     = ($urandom_range(0, 99) < 3);
    berr     = ($urandom_range(0, 99) < 4);
    arb      = ($urandom_range(0, 99) < 4);
    ovr      = ($urandom_range(0, 99) < 6);
    pec      = ($urandom_range(0, 99) < 4);
    tto      = ($urandom_range(0, 99) < 4);
    for (int c = 0; c < 6; c++) clr[c] = ($urandom_range(0, 99) < 6);
    if ($urandom_range(0, 9) == 0) pin = ~pin;
  endtask

  initial begin
    en = 1'b0; master = 1'b0; sbc = 1'b0; reload = 1'b0; auto_end = 1'b0;
    sdis = 1'b0; haddr = 1'b0; aen = 1'b0; cwr = 1'b0; wdata = '0; bdone = 1'b0;
    start = 1'b0; stop = 1'b0; berr = 1'b0; arb = 1'b0; ovr = 1'b0; pec = 1'b0;
    tto = 1'b0; pin = 1'b1; clr = '0;
    // events pending during reset must not show (R12)
    berr = 1'b1; pec = 1'b1; bdone = 1'b1;
    repeat (3) @(negedge clk);
    chk(flags == 8'h00, "R12 flags", int'(flags), 0);
    chk(cnt == '0 && zero, "R12 count", int'(cnt), 0);
    chk(nack == 1'b0, "R12 nack", int'(nack), 0);
    berr = 1'b0; pec = 1'b0; bdone = 1'b0;
    rst_n = 1'b1;
    for (int ph = 0; ph < 16; ph++) begin
      master   = ph[0];
      reload   = ph[1];
      auto_end = (ph % 5 == 4);
      sbc      = ph[2];
      sdis     = ph[2] ^ ph[3];
      haddr    = (ph % 3 != 0);
      aen      = (ph % 6 != 5);
      for (int n = 0; n < 400; n++) begin
        @(negedge clk);
        compare();
        drive(ph);
      end
    end
    @(negedge clk);
    compare();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule